// File: doc/BRIEF.md
# Precision Time Counter with Offset Correction

This block keeps the time of day for a precision time protocol endpoint. A raw counter, clocked by a 125 MHz reference, adds a programmable increment on every cycle. The increment has 20 bits of fractional nanoseconds, which lets a servo outside the block trim the counter's rate within a fixed rail. The nanosecond field rolls over into a 48-bit seconds count. Software loads a time offset, and the block adds it to the raw counter to form the corrected time. The corrected time is what software reads back and what drives the two event outputs.

The block is reached over a simple word-addressed register bus. Writes to the seconds offset words are only staged. The whole offset takes effect in one cycle when the nanosecond offset word is written. A read of the nanosecond value word freezes the corrected seconds into a snapshot, so a later read of the two seconds words gives a consistent time even if the seconds have rolled over in between. The block raises a sticky timer interrupt at every crossing of a fixed nanosecond period. It also produces a media clock that toggles at every crossing of a half-period, shifted by a programmable phase.

Top module: `ptp_tod_clock`

## Requirements
- R1: After reset, the increment reads 0x00800000 (8 ns per cycle), the offsets, phase and time are zero, and `tmr_irq`, `media_clk` and `bus_rdata` are low.
- R2: In every cycle out of reset, the raw time advances by the increment. Increment bits [19:0] are fractional nanoseconds that carry into the nanosecond count, and bits [25:20] are whole nanoseconds.
- R3: When the nanosecond count reaches NS_WRAP, it restarts at the remainder, and the 48-bit seconds count rises by exactly one.
- R4: A write to address 3 stores bits [25:0] of the data, saturated to the range from nominal minus 0x4189 to nominal plus 0x4189. A read of address 3 returns the stored value.
- R5: Corrected time is raw time plus the committed offset. If the nanosecond sum reaches NS_WRAP, NS_WRAP is subtracted from it and the corrected seconds get a carry of one.
- R6: A read of address 4 returns the corrected nanoseconds and captures the corrected seconds. Reads of address 5 (seconds [31:0]) and address 6 (seconds [47:32] in bits [15:0]) return that capture until the next read of address 4.
- R7: Writes to address 1 (seconds offset [31:0]) and address 2 (seconds offset [47:32]) only stage a value. A write to address 0 takes bits [29:0] as the nanosecond offset and commits the staged seconds in the same cycle. Reads of addresses 0, 1 and 2 return the committed nanosecond offset and the staged seconds words.
- R8: `tmr_irq` is set in any cycle where (corrected ns mod IRQ_PERIOD_NS) is lower than in the cycle before. It stays high until a write to address 7, and a set in the same cycle wins over the clear. A read of address 7 returns the flag in bit 0.
- R9: `media_clk` toggles in any cycle where ((corrected ns + phase) mod MEDIA_HALF_NS) is lower than in the cycle before. The phase is bits [29:0] written to address 8, and a read of address 8 returns it.
- R10: Read data appears on `bus_rdata` on the cycle after `bus_rd`, and reads of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read strobe |
| tmr_irq | output | 1 | Sticky periodic timer interrupt |
| media_clk | output | 1 | Media clock derived from corrected time |

## Verification
The bench builds the block with NS_WRAP at 1000, IRQ_PERIOD_NS at 200 and MEDIA_HALF_NS at 100. With these values, the nanosecond rollover and the seconds carry happen every 125 cycles instead of every 125 million. The snapshot can then be tested across a real seconds change, and the offset-sum carry can be tested with a nanosecond offset close to the wrap. Interrupt and media events also occur every few dozen cycles, so a behavioural model of the counter can check both outputs on every clock, including with a non-zero phase and a fractional increment.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
  localparam int NS_W   = 30;
  localparam int SEC_W  = 48;
  localparam int FRAC_W = 20;
  localparam int INC_W  = 26;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 4;

  typedef logic [INC_W-1:0] inc_t;
  typedef logic [NS_W:0]    ns_ext_t;

  localparam logic [ADDR_W-1:0] A_OFF_NS     = 4'd0;
  localparam logic [ADDR_W-1:0] A_OFF_SEC_LO = 4'd1;
  localparam logic [ADDR_W-1:0] A_OFF_SEC_HI = 4'd2;
  localparam logic [ADDR_W-1:0] A_INC        = 4'd3;
  localparam logic [ADDR_W-1:0] A_VAL_NS     = 4'd4;
  localparam logic [ADDR_W-1:0] A_VAL_SEC_LO = 4'd5;
  localparam logic [ADDR_W-1:0] A_VAL_SEC_HI = 4'd6;
  localparam logic [ADDR_W-1:0] A_IRQ        = 4'd7;
  localparam logic [ADDR_W-1:0] A_PHASE      = 4'd8;

  // Saturate a requested increment to nominal +/- rail.
  function automatic inc_t clamp_inc(input inc_t req, input inc_t nom, input inc_t rail);
    inc_t lo, hi;
    lo = nom - rail;
    hi = nom + rail;
    if (req < lo) return lo;
    if (req > hi) return hi;
    return req;
  endfunction

  // One conditional subtraction of the wrap limit.
  function automatic ns_ext_t wrap_once(input ns_ext_t v, input ns_ext_t lim);
    return (v >= lim) ? v - lim : v;
  endfunction

  // A residue that went down means a boundary was crossed.
  function automatic logic residue_dropped(input ns_ext_t cur, input ns_ext_t prev);
    return cur < prev;
  endfunction
endpackage

// File: rtl/tod_accum.sv
module tod_accum
  import ptp_tod_pkg::*;
#(
  parameter int unsigned NS_WRAP = 1000000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  inc_t             inc,
  output logic [NS_W-1:0]  raw_ns,
  output logic [SEC_W-1:0] raw_sec
);
  localparam ns_ext_t WRAP_V = ns_ext_t'(NS_WRAP);
  localparam int      ACC_W  = FRAC_W + NS_W + 1;

  logic [FRAC_W-1:0] frac_q;
  logic [ACC_W-1:0]  acc;
  ns_ext_t           ns_pre;
  logic              wrap_hit;

  always_comb begin
    acc      = {1'b0, raw_ns, frac_q} + ACC_W'(inc);
    ns_pre   = acc[FRAC_W +: NS_W+1];
    wrap_hit = (ns_pre >= WRAP_V);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frac_q  <= '0;
      raw_ns  <= '0;
      raw_sec <= '0;
    end else begin
      frac_q <= acc[FRAC_W-1:0];
      raw_ns <= NS_W'(wrap_once(ns_pre, WRAP_V));
      if (wrap_hit) raw_sec <= raw_sec + SEC_W'(1);
    end
  end

  AST_NS_BELOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ns_ext_t'(raw_ns) < WRAP_V); // R3
  AST_SEC_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_sec == $past(raw_sec)) || (raw_sec == $past(raw_sec) + SEC_W'(1))); // R3
  AST_SEC_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_hit |=> (raw_sec != $past(raw_sec))); // R3
endmodule

// File: rtl/tod_offset_adder.sv
module tod_offset_adder
  import ptp_tod_pkg::*;
#(
  parameter int unsigned NS_WRAP = 1000000000
) (
  input  logic [NS_W-1:0]  raw_ns,
  input  logic [SEC_W-1:0] raw_sec,
  input  logic [NS_W-1:0]  off_ns,
  input  logic [SEC_W-1:0] off_sec,
  output logic [NS_W-1:0]  cor_ns,
  output logic [SEC_W-1:0] cor_sec
);
  localparam ns_ext_t WRAP_V = ns_ext_t'(NS_WRAP);

  ns_ext_t ns_sum;
  logic    carry;

  always_comb begin
    ns_sum  = {1'b0, raw_ns} + {1'b0, off_ns};
    carry   = (ns_sum >= WRAP_V);
    cor_ns  = NS_W'(wrap_once(ns_sum, WRAP_V));
    cor_sec = raw_sec + off_sec + SEC_W'(carry);
  end
endmodule

// File: rtl/tod_event_gen.sv
module tod_event_gen
  import ptp_tod_pkg::*;
#(
  parameter int unsigned IRQ_PERIOD_NS = 125000,
  parameter int unsigned MEDIA_HALF_NS = 62500
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NS_W-1:0] cor_ns,
  input  logic [NS_W-1:0] phase,
  input  logic            irq_clr,
  output logic            irq,
  output logic            media
);
  localparam logic [NS_W-1:0] IRQ_P = NS_W'(IRQ_PERIOD_NS);
  localparam ns_ext_t         MED_P = ns_ext_t'(MEDIA_HALF_NS);

  logic [NS_W-1:0] irq_res, irq_res_q;
  ns_ext_t         med_sum, med_res, med_res_q;
  logic            irq_hit, med_hit;

  always_comb begin
    irq_res = cor_ns % IRQ_P;
    med_sum = {1'b0, cor_ns} + {1'b0, phase};
    med_res = med_sum % MED_P;
    irq_hit = residue_dropped({1'b0, irq_res}, {1'b0, irq_res_q});
    med_hit = residue_dropped(med_res, med_res_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_res_q <= '0;
      med_res_q <= '0;
      irq       <= 1'b0;
      media     <= 1'b0;
    end else begin
      irq_res_q <= irq_res;
      med_res_q <= med_res;
      if (irq_hit)      irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
      if (med_hit) media <= ~media;
    end
  end

  AST_IRQ_SET_ON_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hit |=> irq); // R8
  AST_IRQ_FALL_NEEDS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(irq_clr)); // R8
  AST_MEDIA_TOGGLE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (media != $past(media)) |-> $past(med_hit)); // R9
endmodule

// File: rtl/ptp_tod_clock.sv
module ptp_tod_clock
  import ptp_tod_pkg::*;
#(
  parameter int unsigned NS_WRAP       = 1000000000,
  parameter int unsigned IRQ_PERIOD_NS = 125000,
  parameter int unsigned MEDIA_HALF_NS = 62500,
  parameter int unsigned INC_NOMINAL   = 32'h0080_0000,
  parameter int unsigned INC_RAIL      = 32'h0000_4189
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              tmr_irq,
  output logic              media_clk
);
  localparam inc_t NOM_V  = inc_t'(INC_NOMINAL);
  localparam inc_t RAIL_V = inc_t'(INC_RAIL);
  localparam int   HI_W   = SEC_W - WORD_W;

  inc_t             inc_q;
  logic [NS_W-1:0]  off_ns_q, phase_q;
  logic [SEC_W-1:0] off_sec_q, stage_sec_q, snap_sec_q;
  logic [NS_W-1:0]  raw_ns, cor_ns;
  logic [SEC_W-1:0] raw_sec, cor_sec;

  // Named bus events for the assertions.
  logic commit_w, snap_take_w, irq_clr_w;
  assign commit_w    = bus_wr && (bus_addr == A_OFF_NS);
  assign snap_take_w = bus_rd && (bus_addr == A_VAL_NS);
  assign irq_clr_w   = bus_wr && (bus_addr == A_IRQ);

  tod_accum #(.NS_WRAP(NS_WRAP)) u_accum (
    .clk(clk), .rst_n(rst_n), .inc(inc_q), .raw_ns(raw_ns), .raw_sec(raw_sec)
  );

  tod_offset_adder #(.NS_WRAP(NS_WRAP)) u_adder (
    .raw_ns(raw_ns), .raw_sec(raw_sec), .off_ns(off_ns_q), .off_sec(off_sec_q),
    .cor_ns(cor_ns), .cor_sec(cor_sec)
  );

  tod_event_gen #(.IRQ_PERIOD_NS(IRQ_PERIOD_NS), .MEDIA_HALF_NS(MEDIA_HALF_NS)) u_events (
    .clk(clk), .rst_n(rst_n), .cor_ns(cor_ns), .phase(phase_q),
    .irq_clr(irq_clr_w), .irq(tmr_irq), .media(media_clk)
  );

  // Register writes.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inc_q       <= NOM_V;
      off_ns_q    <= '0;
      off_sec_q   <= '0;
      stage_sec_q <= '0;
      phase_q     <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_OFF_NS: begin
          off_ns_q  <= bus_wdata[NS_W-1:0];
          off_sec_q <= stage_sec_q;
        end
        A_OFF_SEC_LO: stage_sec_q[WORD_W-1:0] <= bus_wdata;
        A_OFF_SEC_HI: stage_sec_q[SEC_W-1:WORD_W] <= bus_wdata[HI_W-1:0];
        A_INC:        inc_q   <= clamp_inc(bus_wdata[INC_W-1:0], NOM_V, RAIL_V);
        A_PHASE:      phase_q <= bus_wdata[NS_W-1:0];
        default: ;
      endcase
    end
  end

  // Register reads and the seconds snapshot.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      snap_sec_q <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        A_OFF_NS:     bus_rdata <= WORD_W'(off_ns_q);
        A_OFF_SEC_LO: bus_rdata <= stage_sec_q[WORD_W-1:0];
        A_OFF_SEC_HI: bus_rdata <= WORD_W'(stage_sec_q[SEC_W-1:WORD_W]);
        A_INC:        bus_rdata <= WORD_W'(inc_q);
        A_VAL_NS: begin
          bus_rdata  <= WORD_W'(cor_ns);
          snap_sec_q <= cor_sec;
        end
        A_VAL_SEC_LO: bus_rdata <= snap_sec_q[WORD_W-1:0];
        A_VAL_SEC_HI: bus_rdata <= WORD_W'(snap_sec_q[SEC_W-1:WORD_W]);
        A_IRQ:        bus_rdata <= WORD_W'(tmr_irq);
        A_PHASE:      bus_rdata <= WORD_W'(phase_q);
        default:      bus_rdata <= '0;
      endcase
    end
  end

  AST_INC_IN_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_q >= NOM_V - RAIL_V) && (inc_q <= NOM_V + RAIL_V)); // R4
  AST_OFFSET_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(off_sec_q) |-> $past(commit_w)); // R7
  AST_SNAP_ONLY_ON_NS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(snap_sec_q) |-> $past(snap_take_w)); // R6
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R10
endmodule

// File: tb/ptp_tod_clock_bench.sv
module ptp_tod_clock_bench;
  localparam int unsigned NS_WRAP = 1000;
  localparam int unsigned IRQ_P   = 200;
  localparam int unsigned MED_P   = 100;
  localparam int unsigned NOM     = 32'h0080_0000;
  localparam int unsigned RAIL    = 32'h0000_4189;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tmr_irq, media_clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  ptp_tod_clock #(.NS_WRAP(NS_WRAP), .IRQ_PERIOD_NS(IRQ_P), .MEDIA_HALF_NS(MED_P)) u_ptp_tod_clock (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_irq(tmr_irq), .media_clk(media_clk)
  );

  // Behavioural reference model.
  int unsigned m_ns, m_frac, m_inc, m_off_ns, m_phase, m_prev_ir, m_prev_mr;
  logic [47:0] m_sec, m_off_sec, m_stage, m_snap;
  logic        m_irq, m_med, exp_valid;
  logic [31:0] exp_rdata;
  string       rd_tag = "R10";
  string       exp_tag = "R10";

  function automatic int unsigned clamp_ref(int unsigned v);
    if (v < NOM - RAIL) return NOM - RAIL;
    if (v > NOM + RAIL) return NOM + RAIL;
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ns = 0; m_frac = 0; m_inc = NOM; m_off_ns = 0; m_phase = 0;
      m_prev_ir = 0; m_prev_mr = 0; m_sec = 0; m_off_sec = 0; m_stage = 0; m_snap = 0;
      m_irq = 0; m_med = 0; exp_valid = 0; exp_rdata = 0;
    end else begin
      int unsigned c_ns, ir, mr;
      logic [47:0] c_sec;
      longint acc;
      c_ns = m_ns + m_off_ns;
      c_sec = m_sec + m_off_sec;
      if (c_ns >= NS_WRAP) begin c_ns = c_ns - NS_WRAP; c_sec = c_sec + 1; end
      ir = c_ns % IRQ_P;
      mr = (c_ns + m_phase) % MED_P;
      exp_valid = bus_rd;
      if (bus_rd) begin
        exp_tag = rd_tag;
        case (bus_addr)
          4'd0: exp_rdata = m_off_ns;
          4'd1: exp_rdata = m_stage[31:0];
          4'd2: exp_rdata = {16'h0, m_stage[47:32]};
          4'd3: exp_rdata = m_inc;
          4'd4: begin exp_rdata = c_ns; m_snap = c_sec; end
          4'd5: exp_rdata = m_snap[31:0];
          4'd6: exp_rdata = {16'h0, m_snap[47:32]};
          4'd7: exp_rdata = {31'h0, m_irq};
          4'd8: exp_rdata = m_phase;
          default: exp_rdata = 0;
        endcase
      end
      if (ir < m_prev_ir) m_irq = 1;
      else if (bus_wr && bus_addr == 4'd7) m_irq = 0;
      if (mr < m_prev_mr) m_med = ~m_med;
      m_prev_ir = ir; m_prev_mr = mr;
      acc = (longint'(m_ns) << 20) + longint'(m_frac) + longint'(m_inc);
      m_frac = int'(acc & 64'hFFFFF);
      m_ns = int'(acc >> 20);
      if (m_ns >= NS_WRAP) begin m_ns = m_ns - NS_WRAP; m_sec = m_sec + 1; end
      if (bus_wr) begin
        case (bus_addr)
          4'd0: begin m_off_ns = bus_wdata[29:0]; m_off_sec = m_stage; end
          4'd1: m_stage[31:0] = bus_wdata;
          4'd2: m_stage[47:32] = bus_wdata[15:0];
          4'd3: m_inc = clamp_ref(bus_wdata[25:0]);
          4'd8: m_phase = bus_wdata[29:0];
          default: ;
        endcase
      end
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check({31'h0, tmr_irq}, {31'h0, m_irq}, "R8");
      check({31'h0, media_clk}, {31'h0, m_med}, "R9");
      if (exp_valid) check(bus_rdata, exp_rdata, exp_tag);
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    @(negedge clk);
    bus_rd = 1; bus_addr = a; rd_tag = tag;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    check(bus_rdata, 32'h0, "R1");
    check({31'h0, tmr_irq}, 32'h0, "R1");
    check({31'h0, media_clk}, 32'h0, "R1");
    rst_n = 1;
    rd(4'd3, "R1");
    rd(4'd0, "R1");
    rd(4'd8, "R1");
    rd(4'd4, "R2");
    idle(130);
    rd(4'd4, "R3");
    rd(4'd5, "R3");
    // Increment saturation and fractional rate.
    wr(4'd3, 32'h00FF_FFFF);
    rd(4'd3, "R4");
    wr(4'd3, 32'h0000_0000);
    rd(4'd3, "R4");
    wr(4'd3, 32'h0080_2000);
    rd(4'd3, "R4");
    idle(50);
    rd(4'd4, "R2");
    // Staged seconds offset has no effect before commit.
    wr(4'd1, 32'h0000_0005);
    wr(4'd2, 32'h0000_0001);
    rd(4'd1, "R7");
    rd(4'd2, "R7");
    rd(4'd4, "R7");
    rd(4'd5, "R7");
    rd(4'd6, "R7");
    // Commit with a nanosecond offset near the wrap.
    wr(4'd0, 32'd990);
    rd(4'd0, "R7");
    rd(4'd4, "R5");
    rd(4'd5, "R5");
    rd(4'd6, "R5");
    // Snapshot held across seconds changes.
    rd(4'd4, "R6");
    idle(300);
    rd(4'd5, "R6");
    rd(4'd6, "R6");
    // Media phase shift.
    wr(4'd8, 32'd37);
    rd(4'd8, "R9");
    idle(200);
    // Interrupt clear.
    for (int i = 0; i < 100 && !tmr_irq; i++) idle(1);
    check({31'h0, tmr_irq}, 32'h1, "R8");
    wr(4'd7, 32'h0);
    rd(4'd7, "R8");
    wr(4'd3, NOM);
    rd(4'd9, "R10");
    rd(4'd15, "R10");
    idle(400);
    rd(4'd4, "R2");
    rd(4'd5, "R3");
    idle(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule